// File: doc/BRIEF.md
# Integer Execute Unit with Multiply Result Registers

This block is the execute stage of a small 32-bit load/store integer core. Each cycle it receives an already-split instruction: a 6-bit major opcode, a 6-bit function field, a 5-bit shift amount, two register operands and a 16-bit immediate. From these it computes a 32-bit result combinationally. A major opcode of 0 selects the register-register group, and the function field then chooses the operation. Any other supported opcode selects an immediate operation that uses the first operand and the immediate.

The unit also keeps two 32-bit multiply result registers, called the high and low halves. A signed or unsigned multiply writes the 64-bit product into them on the clock edge where the multiply is issued with `issue_valid` high. Two move operations read the halves back. Any code the unit does not recognise raises `illegal` and forces the result to zero. The surrounding core handles fetch, the register file, memory access and next-PC selection.

The block has no sequencing states. Its only state is the pair of multiply result registers. They are cleared by reset and are otherwise written only by an issued multiply.

Top module: `int_exec_unit`

## Requirements
- R1: After reset both multiply result halves are zero. Function 16 (opcode 0) returns the high half and function 18 returns the low half.
- R2: Function 24 (opcode 0), issued with `issue_valid` high, stores the signed 64-bit product of `op_a` and `op_b` at the next rising clock edge: bits 31:0 go to the low half and bits 63:32 go to the high half. Both multiply functions drive a result of zero.
- R3: Function 25 (opcode 0), issued with `issue_valid` high, stores the unsigned 64-bit product with the same split as R2.
- R4: The high and low halves keep their values when a multiply is presented with `issue_valid` low, and when any non-multiply operation is issued.
- R5: Function 33 returns `op_a + op_b` and function 35 returns `op_a - op_b`, both taken modulo 2^32.
- R6: Functions 36, 37 and 38 return the bitwise AND, OR and XOR of `op_a` and `op_b`.
- R7: Function 0 shifts `op_b` left by `shamt`, and function 2 shifts it right by `shamt`. Functions 4 and 6 do the same left and right shifts by `op_a[4:0]` and ignore `shamt`. All right shifts fill with zeros.
- R8: Function 42 returns 1 if `op_a < op_b` as signed numbers and 0 otherwise. Function 43 does the same comparison as unsigned numbers.
- R9: Function 8 returns `op_a` unchanged, for use as a jump target.
- R10: Opcode 9 returns `op_a` plus the sign-extended immediate. Opcode 10 returns 1 if `op_a` is less than the sign-extended immediate as signed numbers, and 0 otherwise.
- R11: Opcodes 12, 13 and 14 return the AND, OR and XOR of `op_a` with the zero-extended immediate. Opcode 11 returns 1 if `op_a` is less than the zero-extended immediate as unsigned numbers, and 0 otherwise.
- R12: Opcode 15 returns the immediate in bits 31:16 and zeros in bits 15:0.
- R13: For any unsupported function (opcode 0) or unsupported opcode, `illegal` is 1 and `result` is 0. For every supported code, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the multiply result registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Marks the presented instruction as issued this cycle |
| opcode | input | 6 | Major opcode; 0 selects the register-register group |
| funct | input | 6 | Function field for the register-register group |
| shamt | input | 5 | Constant shift amount |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| illegal | output | 1 | Unsupported code presented |

## Verification
The hardest behaviour to observe at the ports is the multiply state. It is held internally and can only be seen through a later move operation, and a signed product and an unsigned product differ only when an operand has its top bit set. The stimulus therefore uses multiplies with negative and all-ones operands, and follows each one with reads of both halves. To check that the halves are held, the stimulus presents a multiply with the strobe low and an ordinary issued addition, then reads both halves back to confirm they did not change. The immediate compares use operands chosen so that sign extension and zero extension of the immediate give different answers.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_ADDIU = 6'd9;
    localparam logic [5:0] OPC_SLTI  = 6'd10;
    localparam logic [5:0] OPC_SLTIU = 6'd11;
    localparam logic [5:0] OPC_ANDI  = 6'd12;
    localparam logic [5:0] OPC_ORI   = 6'd13;
    localparam logic [5:0] OPC_XORI  = 6'd14;
    localparam logic [5:0] OPC_LUI   = 6'd15;

    localparam logic [5:0] FN_SLL   = 6'd0;
    localparam logic [5:0] FN_SRL   = 6'd2;
    localparam logic [5:0] FN_SLLV  = 6'd4;
    localparam logic [5:0] FN_SRLV  = 6'd6;
    localparam logic [5:0] FN_JR    = 6'd8;
    localparam logic [5:0] FN_MFHI  = 6'd16;
    localparam logic [5:0] FN_MFLO  = 6'd18;
    localparam logic [5:0] FN_MULT  = 6'd24;
    localparam logic [5:0] FN_MULTU = 6'd25;
    localparam logic [5:0] FN_ADDU  = 6'd33;
    localparam logic [5:0] FN_SUBU  = 6'd35;
    localparam logic [5:0] FN_AND   = 6'd36;
    localparam logic [5:0] FN_OR    = 6'd37;
    localparam logic [5:0] FN_XOR   = 6'd38;
    localparam logic [5:0] FN_SLT   = 6'd42;
    localparam logic [5:0] FN_SLTU  = 6'd43;

    typedef enum logic [3:0] {
        K_ZERO, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SHL, K_SHR,
        K_LTS, K_LTU, K_PASS_A, K_HI, K_LO, K_UPPER
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_imm;
        logic      imm_sext;
        logic      var_shift;
        logic      mul_wr;
        logic      mul_signed;
        logic      illegal;
    } dec_t;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
    import int_exec_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output dec_t       dec
);
    dec_t rtype;

    always_comb begin
        rtype = '0;
        unique case (funct)
            FN_SLL:   rtype.kind = K_SHL;
            FN_SRL:   rtype.kind = K_SHR;
            FN_SLLV:  begin rtype.kind = K_SHL; rtype.var_shift = 1'b1; end
            FN_SRLV:  begin rtype.kind = K_SHR; rtype.var_shift = 1'b1; end
            FN_JR:    rtype.kind = K_PASS_A;
            FN_MFHI:  rtype.kind = K_HI;
            FN_MFLO:  rtype.kind = K_LO;
            FN_MULT:  begin rtype.mul_wr = 1'b1; rtype.mul_signed = 1'b1; end
            FN_MULTU: rtype.mul_wr = 1'b1;
            FN_ADDU:  rtype.kind = K_ADD;
            FN_SUBU:  rtype.kind = K_SUB;
            FN_AND:   rtype.kind = K_AND;
            FN_OR:    rtype.kind = K_OR;
            FN_XOR:   rtype.kind = K_XOR;
            FN_SLT:   rtype.kind = K_LTS;
            FN_SLTU:  rtype.kind = K_LTU;
            default:  rtype.illegal = 1'b1;
        endcase
    end

    always_comb begin
        dec = '0;
        unique case (opcode)
            OPC_REG:   dec = rtype;
            OPC_ADDIU: begin dec.kind = K_ADD; dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
            OPC_SLTI:  begin dec.kind = K_LTS; dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
            OPC_SLTIU: begin dec.kind = K_LTU; dec.use_imm = 1'b1; end
            OPC_ANDI:  begin dec.kind = K_AND; dec.use_imm = 1'b1; end
            OPC_ORI:   begin dec.kind = K_OR;  dec.use_imm = 1'b1; end
            OPC_XORI:  begin dec.kind = K_XOR; dec.use_imm = 1'b1; end
            OPC_LUI:   dec.kind = K_UPPER;
            default:   dec.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_exec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  alu_kind_e                  kind,
    input  logic                       use_imm,
    input  logic                       imm_sext,
    input  logic                       var_shift,
    input  logic [$clog2(XLEN)-1:0]    shamt,
    input  logic [XLEN-1:0]            op_a,
    input  logic [XLEN-1:0]            op_b,
    input  logic [IMMW-1:0]            imm,
    input  logic [XLEN-1:0]            hi,
    input  logic [XLEN-1:0]            lo,
    output logic [XLEN-1:0]            result
);
    localparam int SHW = $clog2(XLEN);
    localparam int EXT = XLEN - IMMW;

    logic [XLEN-1:0] imm_wide;
    logic [XLEN-1:0] rhs;
    logic [SHW-1:0]  sh_amt;

    always_comb begin
        imm_wide = imm_sext ? {{EXT{imm[IMMW-1]}}, imm} : {{EXT{1'b0}}, imm};
        rhs      = use_imm ? imm_wide : op_b;
        sh_amt   = var_shift ? op_a[SHW-1:0] : shamt;
        unique case (kind)
            K_ADD:    result = op_a + rhs;
            K_SUB:    result = op_a - rhs;
            K_AND:    result = op_a & rhs;
            K_OR:     result = op_a | rhs;
            K_XOR:    result = op_a ^ rhs;
            K_SHL:    result = op_b << sh_amt;
            K_SHR:    result = op_b >> sh_amt;
            K_LTS:    result = {{(XLEN-1){1'b0}}, ($signed(op_a) < $signed(rhs))};
            K_LTU:    result = {{(XLEN-1){1'b0}}, (op_a < rhs)};
            K_PASS_A: result = op_a;
            K_HI:     result = hi;
            K_LO:     result = lo;
            K_UPPER:  result = {imm, {EXT{1'b0}}};
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_hilo.sv
module int_exec_hilo #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            mul_signed,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0] ext_a, ext_b, product;

    always_comb begin
        ext_a   = {{XLEN{mul_signed & op_a[XLEN-1]}}, op_a};
        ext_b   = {{XLEN{mul_signed & op_b[XLEN-1]}}, op_b};
        product = ext_a * ext_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else if (wr_en) begin
            hi <= product[PW-1:XLEN];
            lo <= product[XLEN-1:0];
        end
    end

    AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(hi) && $stable(lo)));  // R4
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [5:0]      opcode,
    input  logic [5:0]      funct,
    input  logic [SHW-1:0]  shamt,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    dec_t            dec;
    logic [XLEN-1:0] hi_q, lo_q;
    logic [XLEN-1:0] alu_out;

    int_exec_decode u_decode (
        .opcode (opcode),
        .funct  (funct),
        .dec    (dec)
    );

    int_exec_hilo #(.XLEN(XLEN)) u_hilo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (issue_valid & dec.mul_wr),
        .mul_signed (dec.mul_signed),
        .op_a       (op_a),
        .op_b       (op_b),
        .hi         (hi_q),
        .lo         (lo_q)
    );

    int_exec_alu #(.XLEN(XLEN), .IMMW(IMMW)) u_alu (
        .kind      (dec.kind),
        .use_imm   (dec.use_imm),
        .imm_sext  (dec.imm_sext),
        .var_shift (dec.var_shift),
        .shamt     (shamt),
        .op_a      (op_a),
        .op_b      (op_b),
        .imm       (imm),
        .hi        (hi_q),
        .lo        (lo_q),
        .result    (alu_out)
    );

    assign illegal = dec.illegal;
    assign result  = alu_out;

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));  // R13
    AST_COMPARE_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_LTS || dec.kind == K_LTU) |-> (result[XLEN-1:1] == '0));  // R8
    AST_UPPER_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_UPPER) |-> (result[XLEN-IMMW-1:0] == '0));  // R12
    AST_MUL_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec.mul_wr |-> (result == '0 && !illegal));  // R2
endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        illegal;

    typedef struct {
        logic [31:0] res;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .opcode(opcode), .funct(funct), .shamt(shamt),
        .op_a(op_a), .op_b(op_b), .imm(imm),
        .result(result), .illegal(illegal)
    );

    task automatic issue(input string tag, input logic v, input logic [5:0] op,
                         input logic [5:0] fn, input logic [4:0] sh,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [31:0] er, input logic ei);
        exp_t e;
        @(posedge clk);
        #1;
        issue_valid = v; opcode = op; funct = fn; shamt = sh;
        op_a = a; op_b = b; imm = im;
        e.res = er; e.ill = ei; e.tag = tag;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (result !== e.res || illegal !== e.ill) begin
                errors++;
                $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                         e.tag, result, illegal, e.res, e.ill);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        issue("R1 hi after reset", 1, 0, 16, 0, 32'h1, 32'h2, 0, 32'h0, 0);
        issue("R1 lo after reset", 1, 0, 18, 0, 32'h1, 32'h2, 0, 32'h0, 0);
        // R2 signed multiply
        issue("R2 mult result", 1, 0, 24, 0, 32'hFFFFFFFD, 32'd7, 0, 32'h0, 0);
        issue("R2 lo of -3*7", 1, 0, 18, 0, 0, 0, 0, 32'hFFFFFFEB, 0);
        issue("R2 hi of -3*7", 1, 0, 16, 0, 0, 0, 0, 32'hFFFFFFFF, 0);
        issue("R2 mult all-ones", 1, 0, 24, 0, 32'hFFFFFFFF, 32'd2, 0, 32'h0, 0);
        issue("R2 hi of -1*2", 1, 0, 16, 0, 0, 0, 0, 32'hFFFFFFFF, 0);
        // R3 unsigned multiply
        issue("R3 multu result", 1, 0, 25, 0, 32'hFFFFFFFF, 32'd2, 0, 32'h0, 0);
        issue("R3 hi of multu", 1, 0, 16, 0, 0, 0, 0, 32'h00000001, 0);
        issue("R3 lo of multu", 1, 0, 18, 0, 0, 0, 0, 32'hFFFFFFFE, 0);
        // R4 hold
        issue("R4 mult without strobe", 0, 0, 24, 0, 32'd5, 32'd5, 0, 32'h0, 0);
        issue("R4 lo held", 1, 0, 18, 0, 0, 0, 0, 32'hFFFFFFFE, 0);
        issue("R4 addu issued", 1, 0, 33, 0, 32'd1, 32'd2, 0, 32'd3, 0);
        issue("R4 hi held", 1, 0, 16, 0, 0, 0, 0, 32'h00000001, 0);
        // R5
        issue("R5 addu wrap", 1, 0, 33, 0, 32'hFFFFFFFF, 32'd2, 0, 32'd1, 0);
        issue("R5 subu wrap", 1, 0, 35, 0, 32'd0, 32'd1, 0, 32'hFFFFFFFF, 0);
        // R6
        issue("R6 and", 1, 0, 36, 0, 32'hF0F01234, 32'h0FF0FF00, 0, 32'h00F01200, 0);
        issue("R6 or",  1, 0, 37, 0, 32'hF0F01234, 32'h0FF0FF00, 0, 32'hFFF0FF34, 0);
        issue("R6 xor", 1, 0, 38, 0, 32'hF0F01234, 32'h0FF0FF00, 0, 32'hFF00ED34, 0);
        // R7
        issue("R7 sll 31", 1, 0, 0, 31, 0, 32'h1, 0, 32'h80000000, 0);
        issue("R7 srl zero fill", 1, 0, 2, 4, 0, 32'h80000000, 0, 32'h08000000, 0);
        issue("R7 sllv low bits", 1, 0, 4, 7, 32'h23, 32'h1, 0, 32'h8, 0);
        issue("R7 srlv low bits", 1, 0, 6, 9, 32'h24, 32'hF0000000, 0, 32'h0F000000, 0);
        // R8
        issue("R8 slt signed", 1, 0, 42, 0, 32'hFFFFFFFF, 32'd1, 0, 32'd1, 0);
        issue("R8 sltu unsigned", 1, 0, 43, 0, 32'hFFFFFFFF, 32'd1, 0, 32'd0, 0);
        issue("R8 slt equal", 1, 0, 42, 0, 32'd5, 32'd5, 0, 32'd0, 0);
        // R9
        issue("R9 jr pass", 1, 0, 8, 0, 32'h00400058, 32'h1234, 0, 32'h00400058, 0);
        // R10
        issue("R10 addiu negative", 1, 9, 0, 0, 32'd16, 0, 16'hFFFF, 32'd15, 0);
        issue("R10 slti true", 1, 10, 0, 0, 32'hFFFFFFFE, 0, 16'hFFFF, 32'd1, 0);
        issue("R10 slti false", 1, 10, 0, 0, 32'd0, 0, 16'h8000, 32'd0, 0);
        // R11
        issue("R11 andi zext", 1, 12, 0, 0, 32'hFFFFFFFF, 0, 16'h8001, 32'h00008001, 0);
        issue("R11 ori zext", 1, 13, 0, 0, 32'h0, 0, 16'hFFFF, 32'h0000FFFF, 0);
        issue("R11 xori zext", 1, 14, 0, 0, 32'hFFFF0000, 0, 16'hFFFF, 32'hFFFFFFFF, 0);
        issue("R11 sltiu zext false", 1, 11, 0, 0, 32'h00010000, 0, 16'hFFFF, 32'd0, 0);
        issue("R11 sltiu true", 1, 11, 0, 0, 32'd5, 0, 16'd6, 32'd1, 0);
        // R12
        issue("R12 lui", 1, 15, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1001, 32'h10010000, 0);
        // R13
        issue("R13 funct 1", 1, 0, 1, 0, 32'h5, 32'h6, 0, 32'h0, 1);
        issue("R13 funct 26", 1, 0, 26, 0, 32'h5, 32'h6, 0, 32'h0, 1);
        issue("R13 opcode 2", 1, 2, 33, 0, 32'h5, 32'h6, 16'h7, 32'h0, 1);
        issue("R13 opcode 35", 1, 35, 0, 0, 32'h5, 32'h6, 16'h7, 32'h0, 1);
        issue("R13 mult illegal funct no write", 1, 0, 27, 0, 32'h3, 32'h3, 0, 32'h0, 1);
        issue("R13 hi after illegal", 1, 0, 16, 0, 0, 0, 0, 32'h00000001, 0);
        @(posedge clk);
        @(posedge clk);
        finish_run();
    end
endmodule